// File: doc/BRIEF.md
# Multiplexed Cartridge Bus Master

This block runs single-byte read and write cycles on a cartridge connector whose low address byte and data byte share one 8-bit port. A requester presents a 22-bit address, a read/write flag, a write byte and a target code. The block then walks the connector through a fixed sequence. It drives the upper fourteen address lines, strobes the low byte into the cartridge's external latch, and picks the target through two active-low select lines that feed a NAND on the cartridge. It then pulses the output-enable or write-enable strobe. When the cycle is over it returns the read byte together with a one-cycle done pulse.

Every phase lasts a parameterised number of system clock cycles. ROM reads need a long access wait. Save-RAM and internal RAM/I/O reads use a short one. The two writable targets get write-enable pulses of different widths. Before a write to the internal RAM/I/O target, the save-RAM select is pulsed once. After every cycle all selects and strobes stay released for a settle gap before done is raised.

Top module: `cart_bus_master`

## Requirements
- R1: After reset, le is 0; oe_n, we_n, sel_a_n and sel_b_n are 1; ad_oe, busy and done are 0.
- R2: Every cycle begins with an address phase. addr_hi carries address bits 21..8 and stays stable while busy. le is high for LE_CYC cycles with ad_oe=1 and ad_out equal to address bits 7..0. That byte stays driven for HOLD_CYC cycles after le falls. le is never high while oe_n or we_n is low.
- R3: For a read, oe_n is low for exactly the target's read wait, and ad_oe is 0 throughout that time. rd_data takes the ad_in value present in the last low cycle.
- R4: The read wait is ROM_RD_CYC for the ROM target and RAM_RD_CYC for the save-RAM and internal RAM/I/O targets.
- R5: Target code 0 is ROM, 1 is save RAM, 2 is internal RAM/I/O, and 3 also selects ROM. ROM keeps both selects high. Save RAM holds sel_a_n low, and RAM/I/O holds sel_b_n low. The select is held from the start of the address phase to the end of the strobe (LE_CYC+HOLD_CYC+strobe cycles). The two selects are never low together.
- R6: For a write, we_n is low for SRAM_WR_CYC cycles (save RAM) or IO_WR_CYC cycles (RAM/I/O). During that time ad_oe=1 and ad_out equals the write byte.
- R7: A write to the RAM/I/O target first drives sel_a_n low for PULSE_CYC cycles and then high for PULSE_CYC cycles, before sel_b_n falls. Reads of that target have no such pulse.
- R8: A write to the ROM target produces no strobe and no select. It spans SRAM_WR_CYC cycles in place of a strobe and still ends with done.
- R9: busy rises in the cycle after a request is accepted and falls together with the one-cycle done pulse. A request raised while busy is ignored and produces no done.
- R10: After the strobe and select are released, everything stays idle for SETTLE_CYC cycles before done. oe_n and we_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_target | input | 2 | 0 ROM, 1 save RAM, 2 RAM/I/O, 3 ROM |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle end-of-cycle pulse |
| rd_data | output | 8 | Last byte read |
| addr_hi | output | 14 | Address lines 21..8 |
| le | output | 1 | Low-byte latch strobe, active high |
| sel_a_n | output | 1 | Save-RAM select, active low |
| sel_b_n | output | 1 | RAM/I/O select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| ad_out | output | 8 | Value driven on the shared port |
| ad_oe | output | 1 | 1 = drive the shared port |
| ad_in | input | 8 | Value seen on the shared port |

## Verification
Requests go to every target code in both directions, including code 3 and a write to ROM, with addresses at the bottom and top of the space and mixed bit patterns. This shows whether select decoding, strobe width and preamble depend on the right request fields. The bench cartridge model latches the low byte on the falling edge of le and returns a byte computed from the full address. For ROM it returns that byte only after 3 µs of output enable, so a wrong latch byte, a short ROM wait or early sampling each show up as a wrong rd_data. A request raised while busy checks that it is dropped and does not disturb the cycle in flight.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_APL  = 3'd1,
    ST_APH  = 3'd2,
    ST_LEH  = 3'd3,
    ST_LEL  = 3'd4,
    ST_STB  = 3'd5,
    ST_REL  = 3'd6
  } cbm_state_t;

  typedef enum logic [1:0] {
    TGT_ROM  = 2'd0,
    TGT_SRAM = 2'd1,
    TGT_IO   = 2'd2,
    TGT_ALT  = 2'd3
  } cbm_tgt_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic cbm_tgt_t norm_tgt(input logic [1:0] t);
    return (t == 2'd3) ? TGT_ROM : cbm_tgt_t'(t);
  endfunction

endpackage

// File: rtl/cbm_timer.sv
module cbm_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R10: the counter only moves down or reloads, so it never wraps below zero
  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0);
endmodule

// File: rtl/cbm_seq.sv
module cbm_seq
  import cbm_pkg::*;
#(
  parameter int AW          = 22,
  parameter int CW          = 11,
  parameter int ROM_RD_CYC  = 1250,
  parameter int RAM_RD_CYC  = 20,
  parameter int SRAM_WR_CYC = 60,
  parameter int IO_WR_CYC   = 185,
  parameter int LE_CYC      = 4,
  parameter int HOLD_CYC    = 4,
  parameter int PULSE_CYC   = 4,
  parameter int SETTLE_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_target,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  input  logic [7:0]    ad_in,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output cbm_state_t    state,
  output logic          cap_write,
  output cbm_tgt_t      cap_target,
  output logic [AW-1:0] cap_addr,
  output logic [7:0]    cap_wdata,
  output logic [7:0]    rd_data,
  output logic          done,
  output logic          busy
);
  localparam logic [CW-1:0] D_ROM_RD  = CW'(ROM_RD_CYC - 1);
  localparam logic [CW-1:0] D_RAM_RD  = CW'(RAM_RD_CYC - 1);
  localparam logic [CW-1:0] D_SRAM_WR = CW'(SRAM_WR_CYC - 1);
  localparam logic [CW-1:0] D_IO_WR   = CW'(IO_WR_CYC - 1);
  localparam logic [CW-1:0] D_LE      = CW'(LE_CYC - 1);
  localparam logic [CW-1:0] D_HOLD    = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] D_PULSE   = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] D_SETTLE  = CW'(SETTLE_CYC - 1);

  cbm_state_t state_q, state_d;
  logic       accept;
  logic       cap_write_q;
  cbm_tgt_t   cap_tgt_q;
  logic [AW-1:0] cap_addr_q;
  logic [7:0] cap_wdata_q, rd_q, rd_d;
  logic       rd_en, done_q, done_d;

  assign accept = (state_q == ST_IDLE) && req_valid;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid)
                 state_d = (req_write && norm_tgt(req_target) == TGT_IO) ? ST_APL : ST_LEH;
      ST_APL:  if (tmr_zero) state_d = ST_APH;
      ST_APH:  if (tmr_zero) state_d = ST_LEH;
      ST_LEH:  if (tmr_zero) state_d = ST_LEL;
      ST_LEL:  if (tmr_zero) state_d = ST_STB;
      ST_STB:  if (tmr_zero) state_d = ST_REL;
      ST_REL:  if (tmr_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // phase length loaded on each state change
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_APL, ST_APH: tmr_val = D_PULSE;
      ST_LEH:         tmr_val = D_LE;
      ST_LEL:         tmr_val = D_HOLD;
      ST_STB: begin
        if (!cap_write_q)              tmr_val = (cap_tgt_q == TGT_ROM) ? D_ROM_RD : D_RAM_RD;
        else if (cap_tgt_q == TGT_IO)  tmr_val = D_IO_WR;
        else                           tmr_val = D_SRAM_WR;
      end
      ST_REL:         tmr_val = D_SETTLE;
      default:        tmr_val = '0;
    endcase
  end

  always_comb begin
    rd_en  = (state_q == ST_STB) && !cap_write_q && tmr_zero;
    rd_d   = ad_in;
    done_d = (state_q == ST_REL) && tmr_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_write_q <= 1'b0;
      cap_tgt_q   <= TGT_ROM;
      cap_addr_q  <= '0;
      cap_wdata_q <= '0;
    end else if (accept) begin
      cap_write_q <= req_write;
      cap_tgt_q   <= norm_tgt(req_target);
      cap_addr_q  <= req_addr;
      cap_wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign state      = state_q;
  assign cap_write  = cap_write_q;
  assign cap_target = cap_tgt_q;
  assign cap_addr   = cap_addr_q;
  assign cap_wdata  = cap_wdata_q;
  assign rd_data    = rd_q;
  assign done       = done_q;
  assign busy       = (state_q != ST_IDLE);

  // R9: done comes with busy already low, and busy only ends with done
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9: captured request fields do not move while a cycle runs
  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cap_addr_q) && $stable(cap_write_q)));
endmodule

// File: rtl/cbm_pins.sv
module cbm_pins
  import cbm_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cbm_state_t    state,
  input  logic          cap_write,
  input  cbm_tgt_t      cap_target,
  input  logic [AW-1:0] cap_addr,
  input  logic [7:0]    cap_wdata,
  output logic [AW-9:0] addr_hi,
  output logic          le,
  output logic          sel_a_n,
  output logic          sel_b_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [7:0]    ad_out,
  output logic          ad_oe
);
  logic addr_ph, sel_win, wr_stb;

  always_comb begin
    addr_ph = (state == ST_LEH) || (state == ST_LEL);
    sel_win = addr_ph || (state == ST_STB);
    wr_stb  = (state == ST_STB) && cap_write && (cap_target != TGT_ROM);

    addr_hi = cap_addr[AW-1:8];
    le      = (state == ST_LEH);
    sel_a_n = !((state == ST_APL) || (sel_win && cap_target == TGT_SRAM));
    sel_b_n = !(sel_win && cap_target == TGT_IO);
    oe_n    = !((state == ST_STB) && !cap_write);
    we_n    = !wr_stb;
    ad_oe   = addr_ph || wr_stb;
    ad_out  = addr_ph ? cap_addr[7:0] : cap_wdata;
  end

  // R5: the two NAND inputs are never pulled low together
  p_sel_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sel_a_n && !sel_b_n));
  // R10: read and write strobes are exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
endmodule

// File: rtl/cart_bus_master.sv
module cart_bus_master
  import cbm_pkg::*;
#(
  parameter int AW          = 22,
  parameter int ROM_RD_CYC  = 1250,
  parameter int RAM_RD_CYC  = 20,
  parameter int SRAM_WR_CYC = 60,
  parameter int IO_WR_CYC   = 185,
  parameter int LE_CYC      = 4,
  parameter int HOLD_CYC    = 4,
  parameter int PULSE_CYC   = 4,
  parameter int SETTLE_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_target,
  input  logic [21:0]   req_addr,
  input  logic [7:0]    req_wdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rd_data,
  output logic [13:0]   addr_hi,
  output logic          le,
  output logic          sel_a_n,
  output logic          sel_b_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [7:0]    ad_out,
  output logic          ad_oe,
  input  logic [7:0]    ad_in
);
  localparam int MAXD = imax(imax(imax(ROM_RD_CYC, RAM_RD_CYC), imax(SRAM_WR_CYC, IO_WR_CYC)),
                             imax(imax(LE_CYC, HOLD_CYC), imax(PULSE_CYC, SETTLE_CYC)));
  localparam int CW   = $clog2(MAXD + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  cbm_state_t    state;
  logic          cap_write;
  cbm_tgt_t      cap_target;
  logic [AW-1:0] cap_addr;
  logic [7:0]    cap_wdata;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  cbm_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n_i), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  cbm_seq #(
    .AW(AW), .CW(CW), .ROM_RD_CYC(ROM_RD_CYC), .RAM_RD_CYC(RAM_RD_CYC),
    .SRAM_WR_CYC(SRAM_WR_CYC), .IO_WR_CYC(IO_WR_CYC), .LE_CYC(LE_CYC),
    .HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_i), .req_valid(req_valid), .req_write(req_write),
    .req_target(req_target), .req_addr(req_addr), .req_wdata(req_wdata),
    .ad_in(ad_in), .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .state(state), .cap_write(cap_write), .cap_target(cap_target),
    .cap_addr(cap_addr), .cap_wdata(cap_wdata), .rd_data(rd_data),
    .done(done), .busy(busy)
  );

  cbm_pins #(.AW(AW)) u_pins (
    .clk(clk), .rst_n(rst_n_i), .state(state), .cap_write(cap_write),
    .cap_target(cap_target), .cap_addr(cap_addr), .cap_wdata(cap_wdata),
    .addr_hi(addr_hi), .le(le), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .oe_n(oe_n), .we_n(we_n), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  // R2: no latch strobe while a data strobe is active
  p_le_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    le |-> (oe_n && we_n));
  // R2: address byte still driven in the cycle after the latch closes
  p_le_hold_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(le) |-> (ad_oe && $stable(ad_out)));
  // R2: upper address lines hold for the whole cycle
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy && $past(busy)) |-> $stable(addr_hi));
  // R3: the port is released once output enable has been low a cycle
  p_read_dir_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!oe_n && $past(!oe_n)) |-> !ad_oe);
endmodule

// File: tb/sim_cart_bus_master.sv
module sim_cart_bus_master;
  localparam int ROM_RD  = 1250;
  localparam int RAM_RD  = 20;
  localparam int SRAM_WR = 60;
  localparam int IO_WR   = 185;
  localparam int LEC     = 4;
  localparam int HOLDC   = 4;
  localparam int PULSEC  = 4;
  localparam int SETTLEC = 4;
  localparam int ROM_VALID = 750;   // 3 us at 250 MHz
  localparam int RAM_VALID = 3;

  logic clk, rst_n;
  logic req_valid, req_write;
  logic [1:0] req_target;
  logic [21:0] req_addr;
  logic [7:0] req_wdata;
  logic busy, done, le, sel_a_n, sel_b_n, oe_n, we_n, ad_oe;
  logic [7:0] rd_data, ad_out, ad_in;
  logic [13:0] addr_hi;

  cart_bus_master #(
    .ROM_RD_CYC(ROM_RD), .RAM_RD_CYC(RAM_RD), .SRAM_WR_CYC(SRAM_WR), .IO_WR_CYC(IO_WR),
    .LE_CYC(LEC), .HOLD_CYC(HOLDC), .PULSE_CYC(PULSEC), .SETTLE_CYC(SETTLEC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_target(req_target), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .addr_hi(addr_hi), .le(le),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .oe_n(oe_n), .we_n(we_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int issued = 0;
  int dones  = 0;
  bit finished = 0;

  typedef struct {
    logic        wr;
    logic [21:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;
    int oe_w, we_w, sa_low, sb_low, gap, idle;
  } exp_t;
  exp_t q[$];

  function automatic logic [7:0] cart_byte(input logic [21:0] a);
    return (a[7:0] + 8'(a[15:8] * 3)) ^ {2'b10, a[21:16]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: waits for idle, issues one request, queues what it expects
  task automatic issue(input logic wr, input logic [1:0] tgt, input logic [21:0] a,
                       input logic [7:0] wd, input bit poke_busy);
    exp_t e;
    int t, stb;
    t = (tgt == 2'd3) ? 0 : int'(tgt);
    e.wr = wr; e.addr = a; e.wd = wd; e.rd = cart_byte(a);
    e.oe_w = wr ? 0 : ((t == 0) ? ROM_RD : RAM_RD);
    e.we_w = !wr ? 0 : ((t == 1) ? SRAM_WR : (t == 2) ? IO_WR : 0);
    stb = wr ? ((t == 2) ? IO_WR : SRAM_WR) : e.oe_w;
    e.sa_low = (t == 1) ? LEC + HOLDC + stb : ((t == 2 && wr) ? PULSEC : 0);
    e.sb_low = (t == 2) ? LEC + HOLDC + stb : 0;
    e.gap    = (t == 2 && wr) ? PULSEC : -1;
    e.idle   = (t == 0 && wr) ? HOLDC + SRAM_WR + SETTLEC : SETTLEC;
    while (busy) @(negedge clk);
    q.push_back(e);
    issued++;
    req_write = wr; req_target = tgt; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", int'(busy), 1);
    if (poke_busy) begin
      repeat (6) @(negedge clk);
      req_write = 1'b1; req_target = 2'd1; req_addr = 22'h155AA; req_wdata = 8'h99;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor and cartridge model
  logic [7:0]  latch_lo;
  logic [13:0] latch_hi;
  logic prev_le, prev_sa;
  int oe_run, we_run, oe_w, we_w, sa_low, sb_low, gap, idle_run;
  bit a_rose, wd_bad, dir_bad, le_dir_bad;

  task automatic clear_track();
    oe_w = 0; we_w = 0; sa_low = 0; sb_low = 0; gap = 0;
    a_rose = 0; wd_bad = 0; dir_bad = 0; le_dir_bad = 0;
  endtask

  initial begin
    clear_track();
    prev_le = 0; prev_sa = 1; oe_run = 0; we_run = 0; idle_run = 0;
    latch_lo = 0; latch_hi = 0; ad_in = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done) begin
          exp_t e;
          dones++;
          if (q.size() == 0) begin
            chk(0, "R9 unexpected done", dones, issued);
          end else begin
            e = q.pop_front();
            chk({latch_hi, latch_lo} == e.addr, "R2 latched address", int'({latch_hi, latch_lo}), int'(e.addr));
            chk(!le_dir_bad, "R2 port driven while le high", 1, 0);
            chk(oe_w == e.oe_w, "R3 R4 oe_n low width", oe_w, e.oe_w);
            chk(we_w == e.we_w, "R6 R8 we_n low width", we_w, e.we_w);
            chk(sa_low == e.sa_low, "R5 R7 sel_a_n low cycles", sa_low, e.sa_low);
            chk(sb_low == e.sb_low, "R5 sel_b_n low cycles", sb_low, e.sb_low);
            if (e.gap >= 0) chk(gap == e.gap, "R7 gap before sel_b_n", gap, e.gap);
            chk(idle_run == e.idle, "R10 settle before done", idle_run, e.idle);
            if (e.wr) chk(!wd_bad, "R6 write data on port", 1, 0);
            else begin
              chk(!dir_bad, "R3 port released during read", 1, 0);
              chk(rd_data == e.rd, "R3 read data", int'(rd_data), int'(e.rd));
            end
          end
          clear_track();
        end
        // strobe widths
        if (!oe_n) oe_run++; else begin if (oe_run != 0) oe_w = oe_run; oe_run = 0; end
        if (!we_n) we_run++; else begin if (we_run != 0) we_w = we_run; we_run = 0; end
        if (!oe_n && ad_oe && oe_run > 1) dir_bad = 1;
        if (!we_n && !(ad_oe && ad_out == q[0].wd)) wd_bad = 1;
        if (le && !ad_oe) le_dir_bad = 1;
        // selects
        if (!sel_a_n) sa_low++;
        if (!sel_b_n) sb_low++;
        if (!prev_sa && sel_a_n) a_rose = 1;
        if (a_rose && sel_a_n && sel_b_n && sb_low == 0) gap++;
        // latch model: captures on falling le
        if (prev_le && !le) begin latch_lo = ad_out; latch_hi = addr_hi; end
        if (le) latch_lo = ad_out;
        // settle tracking
        if (le || !oe_n || !we_n || !sel_a_n || !sel_b_n) idle_run = 0; else idle_run++;
        // cartridge data
        if (!oe_n && oe_run >= ((sel_a_n && sel_b_n) ? ROM_VALID : RAM_VALID))
          ad_in = cart_byte({latch_hi, latch_lo});
        else
          ad_in = 8'h00;
        prev_le = le; prev_sa = sel_a_n;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_target = 2'd0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk(le == 1'b0, "R1 le", int'(le), 0);
    chk({oe_n, we_n, sel_a_n, sel_b_n} == 4'hF, "R1 strobes and selects high",
        int'({oe_n, we_n, sel_a_n, sel_b_n}), 15);
    chk({ad_oe, busy, done} == 3'b000, "R1 port and status", int'({ad_oe, busy, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({le, oe_n, we_n, sel_a_n, sel_b_n, busy} == 6'b011110, "R1 idle after release",
        int'({le, oe_n, we_n, sel_a_n, sel_b_n, busy}), 30);

    issue(1'b0, 2'd0, 22'h3FFFFF, 8'h00, 0);   // ROM read, top of space (R4)
    issue(1'b0, 2'd0, 22'h000000, 8'h00, 0);   // ROM read, bottom
    issue(1'b0, 2'd1, 22'h007FFF, 8'h00, 0);   // save RAM read (R4, R5)
    issue(1'b1, 2'd1, 22'h001234, 8'hA5, 1);   // save RAM write, poked while busy (R6, R9)
    issue(1'b1, 2'd2, 22'h00FFFF, 8'h28, 0);   // RAM/I/O write with preamble (R7)
    issue(1'b0, 2'd2, 22'h00FEC0, 8'h00, 0);   // RAM/I/O read, no preamble (R7)
    issue(1'b0, 2'd3, 22'h2A5C3B, 8'h00, 0);   // code 3 acts as ROM (R5)
    issue(1'b1, 2'd0, 22'h13579B, 8'h5A, 0);   // write to ROM: no strobe (R8)
    issue(1'b1, 2'd2, 22'h3C0F0F, 8'hC3, 0);   // RAM/I/O write, other pattern (R6)
    while (busy || done) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(dones == issued, "R9 one done per accepted request", dones, issued);
    chk(q.size() == 0, "R9 scoreboard drained", q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule